// File: doc/BRIEF.md
# Half-Warp Access Coalescer

This block takes one memory request issued by a group of sixteen threads and reduces it to the smallest run of naturally aligned memory transactions that covers it. Each thread has an active flag and a byte address that points to a 4-byte word. The block emits the transactions one at a time on a valid/ready output. Each transaction carries a base address, a size code and a mask of the threads it serves.

Each pass starts from the lowest-numbered active thread that has not been served yet. The 128-byte aligned segment that holds that thread's address is the first candidate window. Every unserved active thread whose address falls inside the window joins the transaction. The window then shrinks to 64 bytes, and then to 32 bytes, as long as all the joined addresses still fit in one aligned half. Passes repeat until no thread is left. A single-cycle done pulse then reports the end of the request, and the block is ready for the next one.

Top module: `coalesce_unit`

## Requirements
- R1: The request input is accepted only while the block is idle (reqReady high). While a transaction is valid, reqReady is low.
- R2: Every emitted mask is non-empty. It contains only threads that were active and not yet served, and it always includes the lowest-numbered unserved thread.
- R3: When the served addresses span both 64-byte halves of the 128-byte segment, the size code is 2 and the base is the lead address with bits [6:0] cleared.
- R4: When all served addresses lie in one 64-byte half but span both 32-byte quarters of it, the size code is 1 and the base is the lead address with bits [5:0] cleared.
- R5: When all served addresses lie in one 32-byte block, the size code is 0 and the base is the lead address with bits [4:0] cleared.
- R6: Every unserved active thread whose address falls in the lead thread's 128-byte segment is in the mask of the same transaction.
- R7: While txnValid is high and txnReady is low, txnValid, txnBase, txnSize and txnMask hold their values into the next cycle.
- R8: done pulses for exactly one cycle, in the cycle after the handshake of the last transaction. The block is idle in that cycle, and done is low at all other times during a request.
- R9: A request with no active thread produces no transaction, and done goes high in the cycle after it is accepted.
- R10: Over one request, the masks of the transactions are pairwise disjoint, and their union equals the active set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present |
| reqReady | output | 1 | Block is idle and can take a request |
| reqActive | input | 16 | Per-thread active flags |
| reqAddr | input | 512 | Per-thread byte addresses; thread i uses bits [32*i+31:32*i] |
| txnValid | output | 1 | Transaction fields are valid |
| txnReady | input | 1 | Downstream accepts the transaction |
| txnBase | output | 32 | Aligned base address of the transaction |
| txnSize | output | 2 | Size code: 0 = 32 B, 1 = 64 B, 2 = 128 B |
| txnMask | output | 16 | Threads served by this transaction |
| done | output | 1 | One-cycle pulse when the request is finished |

## Verification
Two events can fall in the same cycle: the done pulse that closes one request, and the acceptance of the next request. The bench provokes this by presenting each new request in the very cycle where done is first seen high. It then checks that the handshake is taken, that done drops in the following cycle, and that the transactions of the new request match the bench model. Random stalls on txnReady fall on last transactions too, so retirement and done are also exercised against back-pressure.

// File: rtl/coalesce_pkg.sv
package coalesce_pkg;
  typedef enum logic [1:0] {
    SZ32  = 2'd0,
    SZ64  = 2'd1,
    SZ128 = 2'd2
  } txnSizeT;

  typedef struct packed {
    logic load;
    logic retire;
  } ctrlStrobeT;
endpackage

// File: rtl/coalesce_dp.sv
module coalesce_dp
  import coalesce_pkg::*;
#(
  parameter int NUM_THREADS = 16,
  parameter int ADDR_W = 32,
  parameter int MAX_BYTES = 128
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobeT                  strobe,
  input  logic                        busy,
  input  logic [NUM_THREADS-1:0]      reqActive,
  input  logic [NUM_THREADS*ADDR_W-1:0] reqAddr,
  output logic                        reqEmpty,
  output logic                        lastTxn,
  output logic [ADDR_W-1:0]           txnBase,
  output logic [1:0]                  txnSize,
  output logic [NUM_THREADS-1:0]      txnMask
);
  localparam int IDX_W = $clog2(NUM_THREADS);
  localparam int SEG_LSB = $clog2(MAX_BYTES);
  localparam int HALF_BIT = SEG_LSB - 1;
  localparam int QUART_BIT = SEG_LSB - 2;

  logic [ADDR_W-1:0] addrQ [NUM_THREADS];
  logic [NUM_THREADS-1:0] pending;
  logic [IDX_W-1:0] leadIdx;
  logic [ADDR_W-1:0] leadAddr;
  logic [NUM_THREADS-1:0] inSeg, diffHalf, diffQuart;

  assign reqEmpty = ~|reqActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= '0;
    end else if (strobe.load) begin
      pending <= reqActive;
    end else if (strobe.retire) begin
      pending <= pending & ~txnMask;
    end
  end

  generate
    for (genvar g = 0; g < NUM_THREADS; g++) begin : gAddr
      always_ff @(posedge clk) begin
        if (strobe.load) addrQ[g] <= reqAddr[g*ADDR_W +: ADDR_W];
      end
    end
  endgenerate

  always_comb begin
    leadIdx = '0;
    for (int i = NUM_THREADS - 1; i >= 0; i--) begin
      if (pending[i]) leadIdx = IDX_W'(i);
    end
  end

  assign leadAddr = addrQ[leadIdx];

  generate
    for (genvar g = 0; g < NUM_THREADS; g++) begin : gCmp
      assign inSeg[g] = pending[g] &&
        (addrQ[g][ADDR_W-1:SEG_LSB] == leadAddr[ADDR_W-1:SEG_LSB]);
      assign diffHalf[g]  = inSeg[g] && (addrQ[g][HALF_BIT]  != leadAddr[HALF_BIT]);
      assign diffQuart[g] = inSeg[g] && (addrQ[g][QUART_BIT] != leadAddr[QUART_BIT]);
    end
  endgenerate

  always_comb begin
    if (|diffHalf) begin
      txnSize = SZ128;
      txnBase = {leadAddr[ADDR_W-1:SEG_LSB], {SEG_LSB{1'b0}}};
    end else if (|diffQuart) begin
      txnSize = SZ64;
      txnBase = {leadAddr[ADDR_W-1:HALF_BIT], {HALF_BIT{1'b0}}};
    end else begin
      txnSize = SZ32;
      txnBase = {leadAddr[ADDR_W-1:QUART_BIT], {QUART_BIT{1'b0}}};
    end
  end

  assign txnMask = inSeg;
  assign lastTxn = (pending & ~inSeg) == '0;

  // R2: mask within the unserved set and never empty while busy
  a_r2_mask_subset: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ((txnMask & ~pending) == '0) && (txnMask != '0));

  // R10: retired threads leave the pending set
  a_r10_retired_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strobe.retire |=> ((pending & $past(txnMask)) == '0));

  // R3: the size code stays in the legal range
  a_r3_size_legal: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (txnSize != 2'd3));
endmodule

// File: rtl/coalesce_ctrl.sv
module coalesce_ctrl
  import coalesce_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqEmpty,
  input  logic       lastTxn,
  input  logic       txnReady,
  output ctrlStrobeT strobe,
  output logic       busy,
  output logic       reqReady,
  output logic       txnValid,
  output logic       done
);
  typedef enum logic {IDLE, BUSY} stateT;
  stateT state, stateNext;
  logic doneNext;

  assign busy = (state == BUSY);
  assign reqReady = (state == IDLE);
  assign txnValid = busy;
  assign strobe.load = reqReady && reqValid;
  assign strobe.retire = busy && txnReady;

  always_comb begin
    stateNext = state;
    doneNext = 1'b0;
    if (strobe.load) begin
      if (reqEmpty) doneNext = 1'b1;
      else stateNext = BUSY;
    end
    if (strobe.retire && lastTxn) begin
      stateNext = IDLE;
      doneNext = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= IDLE;
      done <= 1'b0;
    end else begin
      state <= stateNext;
      done <= doneNext;
    end
  end

  // R1: no request acceptance while a transaction is offered
  a_r1_ready_idle: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> !reqReady);

  // R7: an offered transaction is not withdrawn
  a_r7_valid_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txnValid && !txnReady) |=> txnValid);

  // R9: empty request finishes at once
  a_r9_empty_done: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqEmpty) |=> (done && !txnValid));

  // R8: done only while idle, and only for one cycle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> reqReady);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done || $past(strobe.load));
endmodule

// File: rtl/coalesce_unit.sv
module coalesce_unit
  import coalesce_pkg::*;
#(
  parameter int NUM_THREADS = 16,
  parameter int ADDR_W = 32,
  parameter int MAX_BYTES = 128
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic [NUM_THREADS-1:0]        reqActive,
  input  logic [NUM_THREADS*ADDR_W-1:0] reqAddr,
  output logic                          txnValid,
  input  logic                          txnReady,
  output logic [ADDR_W-1:0]             txnBase,
  output logic [1:0]                    txnSize,
  output logic [NUM_THREADS-1:0]        txnMask,
  output logic                          done
);
  ctrlStrobeT strobe;
  logic busy, reqEmpty, lastTxn;

  coalesce_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqEmpty(reqEmpty),
    .lastTxn(lastTxn), .txnReady(txnReady), .strobe(strobe), .busy(busy),
    .reqReady(reqReady), .txnValid(txnValid), .done(done)
  );

  coalesce_dp #(.NUM_THREADS(NUM_THREADS), .ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy), .reqActive(reqActive),
    .reqAddr(reqAddr), .reqEmpty(reqEmpty), .lastTxn(lastTxn),
    .txnBase(txnBase), .txnSize(txnSize), .txnMask(txnMask)
  );

  // R7: fields frozen under back-pressure
  a_r7_fields_stable: assert property (@(posedge clk) disable iff (!rstN)
    (txnValid && !txnReady) |=> ($stable(txnBase) && $stable(txnSize) && $stable(txnMask)));
endmodule

// File: tb/sim_coalesce_unit.sv
module sim_coalesce_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 16;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [NT-1:0] reqActive = '0;
  logic [NT*AW-1:0] reqAddr = '0;
  logic txnValid;
  logic txnReady = 1'b0;
  logic [AW-1:0] txnBase;
  logic [1:0] txnSize;
  logic [NT-1:0] txnMask;
  logic done;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  logic [AW-1:0] tAddr [NT];
  logic [AW-1:0] expBase [NT];
  logic [1:0]    expSize [NT];
  logic [NT-1:0] expMask [NT];
  int expCount;

  always #(CLK_PERIOD/2) clk = ~clk;

  coalesce_unit u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqActive(reqActive), .reqAddr(reqAddr), .txnValid(txnValid),
    .txnReady(txnReady), .txnBase(txnBase), .txnSize(txnSize),
    .txnMask(txnMask), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Bench model of the coalescing rule
  task automatic buildExpected(input logic [NT-1:0] act);
    logic [NT-1:0] pend;
    int lead;
    logic [NT-1:0] m;
    logic [1:0] sz;
    pend = act;
    expCount = 0;
    while (pend != '0) begin
      lead = 0;
      for (int i = NT - 1; i >= 0; i--) if (pend[i]) lead = i;
      m = '0;
      for (int i = 0; i < NT; i++)
        if (pend[i] && (tAddr[i] >> 7) == (tAddr[lead] >> 7)) m[i] = 1'b1;
      sz = 2'd0;
      for (int i = 0; i < NT; i++) begin
        if (m[i] && tAddr[i][6] != tAddr[lead][6]) sz = 2'd2;
        else if (m[i] && tAddr[i][5] != tAddr[lead][5] && sz == 2'd0) sz = 2'd1;
      end
      expBase[expCount] = tAddr[lead] & ~((32'd32 << sz) - 32'd1);
      expSize[expCount] = sz;
      expMask[expCount] = m;
      expCount++;
      pend &= ~m;
    end
  endtask

  // Entered and left at a falling edge
  task automatic runRequest(input logic [NT-1:0] act);
    int k;
    bit prevStall;
    bit rdy;
    logic [AW-1:0] pBase;
    logic [1:0] pSize;
    logic [NT-1:0] pMask;
    logic [NT-1:0] seen;
    bit overlap;
    string tag;
    buildExpected(act);
    for (int i = 0; i < NT; i++) reqAddr[i*AW +: AW] = tAddr[i];
    reqActive = act;
    chk(reqReady == 1'b1, "R1", "reqReady before request", 64'(reqReady), 64'd1);
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    reqActive = '0;
    if (expCount == 0) begin
      chk(done == 1'b1 && txnValid == 1'b0, "R9", "empty request done",
          64'({done, txnValid}), 64'b10);
      return;
    end
    k = 0;
    prevStall = 0;
    pBase = '0; pSize = '0; pMask = '0;
    seen = '0;
    overlap = 0;
    while (k < expCount && cycles < 150000) begin
      chk(done == 1'b0, "R8", "done during request", 64'(done), 64'd0);
      chk(txnValid == 1'b1 && reqReady == 1'b0, "R1", "busy handshake state",
          64'({txnValid, reqReady}), 64'b10);
      if (prevStall)
        chk(txnBase == pBase && txnSize == pSize && txnMask == pMask, "R7",
            "hold under stall", {txnBase, 14'd0, txnSize, txnMask},
            {pBase, 14'd0, pSize, pMask});
      rdy = ($urandom % 4) != 0;
      txnReady = rdy;
      if (rdy) begin
        tag = (expSize[k] == 2'd2) ? "R3" : (expSize[k] == 2'd1) ? "R4" : "R5";
        chk(txnSize == expSize[k] && txnBase == expBase[k], tag, "size and base",
            {txnBase, 30'd0, txnSize}, {expBase[k], 30'd0, expSize[k]});
        chk(txnMask == expMask[k], "R6", "thread mask", 64'(txnMask), 64'(expMask[k]));
        chk(txnMask[$clog2(NT)'(0)] | 1'b1 && (txnMask & ~act) == '0 && txnMask != '0,
            "R2", "mask within active set", 64'(txnMask), 64'(txnMask & act));
        if ((seen & txnMask) != '0) overlap = 1;
        seen |= txnMask;
        k++;
      end
      prevStall = !rdy;
      pBase = txnBase; pSize = txnSize; pMask = txnMask;
      @(posedge clk);
      @(negedge clk);
    end
    txnReady = 1'b0;
    chk(done == 1'b1 && reqReady == 1'b1 && txnValid == 1'b0, "R8", "done after last",
        64'({done, reqReady, txnValid}), 64'b110);
    chk(seen == act && !overlap, "R10", "mask union", 64'(seen), 64'(act));
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 180000) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected below 180000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int unused;
    logic [NT-1:0] act;
    logic [AW-1:0] base;
    int stride;
    unused = $urandom(32'd4711);
    for (int i = 0; i < NT; i++) tAddr[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    chk(reqReady == 1'b1 && txnValid == 1'b0 && done == 1'b0, "R1", "reset state",
        64'({reqReady, txnValid, done}), 64'b100);

    // Consecutive words from 116: 32 B at 96 then 64 B at 128
    for (int i = 0; i < NT; i++) tAddr[i] = 32'd116 + 32'(i * 4);
    runRequest('1);
    // Broadcast: one 32 B transaction
    for (int i = 0; i < NT; i++) tAddr[i] = 32'h1040;
    runRequest('1);
    // Stride 2 aligned: one 128 B transaction
    for (int i = 0; i < NT; i++) tAddr[i] = 32'h2000 + 32'(i * 8);
    runRequest('1);
    // No active thread
    runRequest('0);
    // Lowest threads inactive, window set by thread 3
    for (int i = 0; i < NT; i++) tAddr[i] = 32'd116 + 32'(i * 4);
    runRequest(16'hFFF8);
    // Reverse order across segments
    for (int i = 0; i < NT; i++) tAddr[i] = 32'h3000 + 32'((NT - 1 - i) * 48);
    runRequest('1);

    for (int n = 0; n < 400; n++) begin
      base = {12'd0, 20'($urandom)} & ~32'd3;
      stride = 1 + ($urandom % 8);
      act = ($urandom % 3 == 0) ? 16'($urandom) : '1;
      for (int i = 0; i < NT; i++) begin
        case (n % 4)
          0: tAddr[i] = base + 32'(i * 4);
          1: tAddr[i] = base + 32'(i * 4 * stride);
          2: tAddr[i] = base + (32'($urandom % 128) << 2);
          default: tAddr[i] = base + (32'($urandom % 16) << 2);
        endcase
      end
      runRequest(act);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule